// File: doc/BRIEF.md
# Dispatch Bandwidth Gate with Carry-Over

This block decides, each clock, which of a small group of in-order instruction slots may dispatch. Each slot presents a micro-op count and three readiness bits: reorder buffer room, rename register room and scheduler buffer room. A slot passes only when its readiness bits are all high, the per-cycle dispatch bandwidth allows it, and every older slot in the same clock also passed. Every clock is one dispatch cycle.

Bandwidth is tracked as a count of free entries that is refilled at each clock edge. An instruction with more micro-ops than the dispatch width may still pass, but only in a slot that sees the full width free. Its surplus micro-ops become a carry-over debt that shrinks the free entries of the following cycles until the debt is paid.

When a slot is held back for lack of a resource, a stall code names the first missing resource. One saturating counter per resource records how many cycles were stalled for that reason.

Top module: `dispatch_gate`

## Requirements
- R1: After a synchronous active-low reset, all three stall counters read zero, the carry-over debt is zero and the full dispatch width is free. With no valid slot, `accept` and `stall_code` are zero.
- R2: A valid slot asking for N micro-ops passes the bandwidth test when N is at most the entries still free, or when the free entries still equal the full width.
- R3: Slot i (bit i of each per-slot vector, slot 0 the oldest) can be accepted only if slot i-1 is accepted in the same clock. An accepted slot consumes min(N, free) entries from what the younger slots see.
- R4: The surplus N - min(N, free) of an accepted slot is added to a carry-over debt. At each clock edge the free entries become zero if the debt is at least the width, and otherwise the width minus the debt. The debt is reduced by the width, with a floor of zero.
- R5: A slot whose reorder-buffer, rename or scheduler readiness bit is low is never accepted.
- R6: `stall_code` describes the oldest valid slot that is not accepted. It is 1 if its reorder buffer bit is low, else 2 if its rename bit is low, else 3 if its scheduler bit is low. It is 0 when that slot is held back by bandwidth only, or when every valid slot is accepted.
- R7: At each clock edge the counter matching a nonzero `stall_code` (1 reorder buffer, 2 rename, 3 scheduler) increments by one. When the code is 0, no counter changes.
- R8: Each stall counter holds at its all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each edge ends a dispatch cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | SLOTS | Slot holds an instruction |
| req_uops | input | SLOTS*UOP_W | Micro-op count per slot, slot i at bits [i*UOP_W +: UOP_W] |
| rob_room | input | SLOTS | Reorder buffer can take the slot's micro-ops |
| ren_room | input | SLOTS | Rename registers are free for the slot's outputs |
| sch_room | input | SLOTS | Scheduler buffers can take the slot |
| accept | output | SLOTS | Slot dispatches this cycle |
| stall_code | output | 2 | Resource stall reason, encoded as in R6 |
| cnt_rob | output | CNT_W | Reorder-buffer stall cycles, saturating |
| cnt_ren | output | CNT_W | Rename stall cycles, saturating |
| cnt_sch | output | CNT_W | Scheduler stall cycles, saturating |

## Verification
The bench builds the gate with a width of 4, two slots, 4-bit micro-op counts and 4-bit counters. Counts up to 15 allow a debt of 11, which keeps bandwidth at zero for two full cycles and then leaves a partial refill. They also allow an oversized request of twice the width or more, so the blocked-cycle case is reachable. The narrow counters reach saturation after fifteen stalled cycles, so the R8 corner is exercised directly rather than left to the assertions.

// File: rtl/dgate_pkg.sv
// Shared types for the dispatch bandwidth gate.
package dgate_pkg;
    // Stall reason; numeric values are visible on the stall_code port.
    typedef enum logic [1:0] {
        STALL_NONE = 2'd0,
        STALL_ROB  = 2'd1,
        STALL_REN  = 2'd2,
        STALL_SCH  = 2'd3
    } stall_e;
endpackage

// File: rtl/dgate_lane_chain.sv
// Combinational in-order slot evaluation for one dispatch cycle.
// Walks slots from oldest to youngest and spends free bandwidth entries.
// Surplus micro-ops of an accepted slot are accumulated into the outgoing debt.
// Also picks the stall reason of the oldest blocked slot.
// Assumes: avail_q never exceeds WIDTH; a younger slot is considered only
// when every older slot was accepted.
module dgate_lane_chain #(
    parameter int WIDTH = 4,
    parameter int SLOTS = 2,
    parameter int UOP_W = 4,
    parameter int AV_W  = 3,
    parameter int CE_W  = 5
) (
    input  logic [AV_W-1:0]        avail_q,
    input  logic [CE_W-1:0]        carry_q,
    input  logic [SLOTS-1:0]       req_valid,
    input  logic [SLOTS*UOP_W-1:0] req_uops,
    input  logic [SLOTS-1:0]       rob_room,
    input  logic [SLOTS-1:0]       ren_room,
    input  logic [SLOTS-1:0]       sch_room,
    output logic [SLOTS-1:0]       accept,
    output logic [CE_W-1:0]        carry_end,
    output dgate_pkg::stall_e      stall_code
);
    int   av;
    int   cr;
    int   n;
    int   take;
    logic prev_ok;

    // Spend bandwidth slot by slot and record the first resource stall.
    always_comb begin
        av         = int'(avail_q);
        cr         = int'(carry_q);
        n          = 0;
        take       = 0;
        prev_ok    = 1'b1;
        accept     = '0;
        stall_code = dgate_pkg::STALL_NONE;
        for (int i = 0; i < SLOTS; i++) begin
            n = int'(req_uops[i*UOP_W +: UOP_W]);
            accept[i] = prev_ok && req_valid[i] && ((n <= av) || (av == WIDTH))
                        && rob_room[i] && ren_room[i] && sch_room[i];
            if (accept[i]) begin
                take = (n < av) ? n : av;
                av   = av - take;
                cr   = cr + n - take;
            end else if (prev_ok && req_valid[i]) begin
                if (!rob_room[i])      stall_code = dgate_pkg::STALL_ROB;
                else if (!ren_room[i]) stall_code = dgate_pkg::STALL_REN;
                else if (!sch_room[i]) stall_code = dgate_pkg::STALL_SCH;
                else                   stall_code = dgate_pkg::STALL_NONE;
            end
            prev_ok = accept[i];
        end
        carry_end = CE_W'(cr);
    end
endmodule

// File: rtl/dgate_credit.sv
// Bandwidth state across cycle boundaries: free entries and carry-over debt.
// At each edge the free entries are rebuilt from the debt alone. Entries left
// unused in a cycle are not saved.
// Assumes: carry_end never exceeds the largest micro-op count minus WIDTH.
module dgate_credit #(
    parameter int WIDTH = 4,
    parameter int AV_W  = 3,
    parameter int CE_W  = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CE_W-1:0] carry_end,
    output logic [AV_W-1:0] avail_q,
    output logic [CE_W-1:0] carry_q
);
    // Refill free entries and pay down the debt by one width per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            avail_q <= AV_W'(WIDTH);
            carry_q <= '0;
        end else if (int'(carry_end) >= WIDTH) begin
            avail_q <= '0;
            carry_q <= CE_W'(int'(carry_end) - WIDTH);
        end else begin
            avail_q <= AV_W'(WIDTH - int'(carry_end));
            carry_q <= '0;
        end
    end
endmodule

// File: rtl/dgate_sat_cnt.sv
// Saturating event counter.
// Assumes: one event at most per clock.
module dgate_sat_cnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    // Count events and hold at all-ones.
    always_ff @(posedge clk) begin
        if (!rst_n)                  count <= '0;
        else if (inc && count != '1) count <= count + 1'b1;
    end
endmodule

// File: rtl/dispatch_gate.sv
// Dispatch bandwidth gate with carry-over and per-reason stall counters.
// Combines the per-cycle width limit with three resource readiness bits per slot.
// Assumes: slots are presented oldest first from bit 0; each clock is one cycle.
module dispatch_gate #(
    parameter int WIDTH = 4,
    parameter int SLOTS = 2,
    parameter int UOP_W = 4,
    parameter int CNT_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SLOTS-1:0]       req_valid,
    input  logic [SLOTS*UOP_W-1:0] req_uops,
    input  logic [SLOTS-1:0]       rob_room,
    input  logic [SLOTS-1:0]       ren_room,
    input  logic [SLOTS-1:0]       sch_room,
    output logic [SLOTS-1:0]       accept,
    output logic [1:0]             stall_code,
    output logic [CNT_W-1:0]       cnt_rob,
    output logic [CNT_W-1:0]       cnt_ren,
    output logic [CNT_W-1:0]       cnt_sch
);
    localparam int AV_W  = $clog2(WIDTH + 1);
    localparam int CE_W  = UOP_W + 1;
    localparam int NREAS = 3;

    logic [AV_W-1:0]   avail_q;
    logic [CE_W-1:0]   carry_q;
    logic [CE_W-1:0]   carry_end;
    dgate_pkg::stall_e code_e;
    logic [CNT_W-1:0]  cnt_arr [NREAS];

    dgate_lane_chain #(
        .WIDTH(WIDTH), .SLOTS(SLOTS), .UOP_W(UOP_W), .AV_W(AV_W), .CE_W(CE_W)
    ) u_chain (
        .avail_q(avail_q), .carry_q(carry_q), .req_valid(req_valid),
        .req_uops(req_uops), .rob_room(rob_room), .ren_room(ren_room),
        .sch_room(sch_room), .accept(accept), .carry_end(carry_end),
        .stall_code(code_e)
    );

    dgate_credit #(
        .WIDTH(WIDTH), .AV_W(AV_W), .CE_W(CE_W)
    ) u_credit (
        .clk(clk), .rst_n(rst_n), .carry_end(carry_end),
        .avail_q(avail_q), .carry_q(carry_q)
    );

    assign stall_code = code_e;

    // One saturating counter per stall reason, indexed by code minus one.
    for (genvar k = 0; k < NREAS; k++) begin : g_cnt
        dgate_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n),
            .inc(stall_code == 2'(k + 1)),
            .count(cnt_arr[k])
        );
    end

    assign cnt_rob = cnt_arr[0];
    assign cnt_ren = cnt_arr[1];
    assign cnt_sch = cnt_arr[2];
endmodule

// File: rtl/dispatch_gate_chk.sv
// Property checker for dispatch_gate, attached through bind below.
module dispatch_gate_chk #(
    parameter int WIDTH = 4,
    parameter int SLOTS = 2,
    parameter int UOP_W = 4,
    parameter int CNT_W = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [SLOTS-1:0]       req_valid,
    input logic [SLOTS*UOP_W-1:0] req_uops,
    input logic [SLOTS-1:0]       rob_room,
    input logic [SLOTS-1:0]       ren_room,
    input logic [SLOTS-1:0]       sch_room,
    input logic [SLOTS-1:0]       accept,
    input logic [1:0]             stall_code,
    input logic [CNT_W-1:0]       cnt_rob,
    input logic [CNT_W-1:0]       cnt_ren,
    input logic [CNT_W-1:0]       cnt_sch
);
    // R3: a younger slot never passes an older one.
    for (genvar i = 1; i < SLOTS; i++) begin : g_order
        assert_in_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
            accept[i] |-> accept[i-1]);
    end

    // R5: acceptance needs every readiness bit of the slot.
    assert_res_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept & ~(rob_room & ren_room & sch_room)) == '0);

    // R6: a nonzero reason only appears with a valid slot left behind.
    assert_code_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_code != 2'd0) |-> ((req_valid & ~accept) != '0));

    // R4: an oversized start of two widths or more leaves no bandwidth next cycle.
    assert_debt_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept[0] && int'(req_uops[UOP_W-1:0]) >= 2 * WIDTH)
        |=> !(accept[0] && req_uops[UOP_W-1:0] != '0));

    // R7: a zero code leaves every counter unchanged.
    assert_no_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_code == 2'd0) |=> ($stable(cnt_rob) && $stable(cnt_ren) && $stable(cnt_sch)));

    // R8: an all-ones counter stays all-ones.
    assert_sat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_sch == '1) |=> (cnt_sch == '1));
endmodule

bind dispatch_gate dispatch_gate_chk #(
    .WIDTH(WIDTH), .SLOTS(SLOTS), .UOP_W(UOP_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_uops(req_uops),
    .rob_room(rob_room), .ren_room(ren_room), .sch_room(sch_room),
    .accept(accept), .stall_code(stall_code), .cnt_rob(cnt_rob),
    .cnt_ren(cnt_ren), .cnt_sch(cnt_sch)
);

// File: tb/dispatch_gate_test.sv
`timescale 1ns/1ps
// Directed bench for dispatch_gate: one task per scenario.
module dispatch_gate_test;
    localparam int W  = 4;
    localparam int S  = 2;
    localparam int UW = 4;
    localparam int CW = 4;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [S-1:0]  req_valid = '0;
    logic [S*UW-1:0] req_uops = '0;
    logic [S-1:0]  rob_room = '1;
    logic [S-1:0]  ren_room = '1;
    logic [S-1:0]  sch_room = '1;
    logic [S-1:0]  accept;
    logic [1:0]    stall_code;
    logic [CW-1:0] cnt_rob, cnt_ren, cnt_sch;

    int n_chk = 0;
    int n_bad = 0;
    int e_rob = 0, e_ren = 0, e_sch = 0;
    bit done = 1'b0;

    dispatch_gate #(.WIDTH(W), .SLOTS(S), .UOP_W(UW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_uops(req_uops),
        .rob_room(rob_room), .ren_room(ren_room), .sch_room(sch_room),
        .accept(accept), .stall_code(stall_code), .cnt_rob(cnt_rob),
        .cnt_ren(cnt_ren), .cnt_sch(cnt_sch)
    );

    always #4 clk = ~clk;

    task automatic check(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    function automatic int bump(input int v);
        return (v < CMAX) ? v + 1 : v;
    endfunction

    // One dispatch cycle: drive at negedge, check outputs, pass the edge.
    task automatic cyc(input logic [1:0] v, input int u0, input int u1,
                       input logic [1:0] rob, input logic [1:0] ren,
                       input logic [1:0] sch, input logic [1:0] eacc,
                       input int ecode, input string rq);
        req_valid = v;
        req_uops  = {UW'(u1), UW'(u0)};
        rob_room  = rob;
        ren_room  = ren;
        sch_room  = sch;
        #1;
        check({rq, " accept"}, int'(accept), int'(eacc));
        check({rq, " code"}, int'(stall_code), ecode);
        if (ecode == 1) e_rob = bump(e_rob);
        if (ecode == 2) e_ren = bump(e_ren);
        if (ecode == 3) e_sch = bump(e_sch);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) cyc(2'b00, 0, 0, 2'b11, 2'b11, 2'b11, 2'b00, 0, "idle");
    endtask

    task automatic chk_cnt(input string rq);
        check({rq, " cnt_rob"}, int'(cnt_rob), e_rob);
        check({rq, " cnt_ren"}, int'(cnt_ren), e_ren);
        check({rq, " cnt_sch"}, int'(cnt_sch), e_sch);
    endtask

    // R1: reset state and full width free afterwards.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 accept idle", int'(accept), 0);
        check("R1 code idle", int'(stall_code), 0);
        chk_cnt("R1");
        cyc(2'b11, 4, 0, 2'b11, 2'b11, 2'b11, 2'b11, 0, "R1 full width");
    endtask

    // R2 R3: bandwidth shared by slots in order.
    task automatic t_bandwidth();
        cyc(2'b11, 3, 1, 2'b11, 2'b11, 2'b11, 2'b11, 0, "R2 exact fill");
        cyc(2'b11, 2, 3, 2'b11, 2'b11, 2'b11, 2'b01, 0, "R2 young over");
        cyc(2'b11, 2, 2, 2'b11, 2'b11, 2'b11, 2'b11, 0, "R3 split");
        cyc(2'b11, 1, 6, 2'b11, 2'b11, 2'b11, 2'b01, 0, "R2 oversize not at start");
        chk_cnt("R7 bandwidth only");
    endtask

    // R4: oversized start and debt repayment.
    task automatic t_carry();
        cyc(2'b11, 10, 1, 2'b11, 2'b11, 2'b11, 2'b01, 0, "R4 oversize start");
        cyc(2'b01, 1, 0, 2'b11, 2'b11, 2'b11, 2'b00, 0, "R4 debt blocks");
        cyc(2'b11, 2, 1, 2'b11, 2'b11, 2'b11, 2'b01, 0, "R4 partial refill");
        cyc(2'b01, 4, 0, 2'b11, 2'b11, 2'b11, 2'b01, 0, "R4 full again");
        cyc(2'b01, 5, 0, 2'b11, 2'b11, 2'b11, 2'b01, 0, "R4 small surplus");
        cyc(2'b01, 4, 0, 2'b11, 2'b11, 2'b11, 2'b00, 0, "R4 width minus debt");
        cyc(2'b01, 4, 0, 2'b11, 2'b11, 2'b11, 2'b01, 0, "R4 refilled");
        chk_cnt("R7 carry");
    endtask

    // R5 R6 R7: resource stalls and reason priority.
    task automatic t_resources();
        cyc(2'b01, 1, 0, 2'b10, 2'b11, 2'b11, 2'b00, 1, "R5 R6 rob");
        cyc(2'b01, 1, 0, 2'b11, 2'b10, 2'b10, 2'b00, 2, "R5 R6 ren");
        cyc(2'b01, 1, 0, 2'b11, 2'b11, 2'b10, 2'b00, 3, "R5 R6 sch");
        cyc(2'b11, 1, 1, 2'b11, 2'b01, 2'b11, 2'b01, 2, "R6 young ren");
        cyc(2'b01, 1, 0, 2'b10, 2'b10, 2'b10, 2'b00, 1, "R6 all low");
        chk_cnt("R7 counts");
    endtask

    // R3: a blocked old slot holds back a ready young one.
    task automatic t_order();
        cyc(2'b11, 1, 1, 2'b10, 2'b11, 2'b11, 2'b00, 1, "R3 hold young");
        chk_cnt("R3 R7");
    endtask

    // R8: counter saturation.
    task automatic t_saturate();
        for (int i = 0; i < 16; i++)
            cyc(2'b01, 1, 0, 2'b11, 2'b11, 2'b10, 2'b00, 3, "R8 sch stall");
        check("R8 saturated", int'(cnt_sch), CMAX);
        cyc(2'b01, 1, 0, 2'b11, 2'b11, 2'b10, 2'b00, 3, "R8 hold");
        check("R8 no wrap", int'(cnt_sch), CMAX);
        chk_cnt("R8");
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_bandwidth();
        idle(4);
        t_carry();
        idle(4);
        t_resources();
        t_order();
        t_saturate();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end
endmodule